// File: doc/BRIEF.md
# Page Buffer with Deferred Commit

This block holds a small staging buffer in front of two byte-addressed register-file arrays. One array is program memory, organised as 16-bit words. The other is data memory, organised as bytes. Load requests place single bytes into the staging buffer and change nothing in either array. A separate commit request then copies the staged bytes into the page named by the upper address bits. Only bytes that were actually loaded reach the array. After a commit, the block reports busy for a fixed self-timed interval.

Program words are staged as a low byte and a high byte. A high byte is accepted only after the low byte of the same word has been staged. Data memory can also be written one byte at a time, without the buffer. Such a write replaces the old value directly, because the erase is implied and no prior erase step is needed. While busy, every request is refused and flagged. A combinational read port exposes the arrays so that their contents can be checked.

Top module: `pgbuf_commit`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `err_order` and `err_busy` are 0 and every byte of both arrays reads 0xFF.
- R2: Operation codes on `req_op` are 0 none, 1 stage program low byte, 2 stage program high byte, 3 commit program page, 4 stage data byte, 5 commit data page, 6 single data byte write, 7 none. A program load is indexed by `req_addr[4:0]`, and the page bits of the load are ignored. A program commit writes the staged word at index w to word address `{req_addr[7:5], w}`.
- R3: A high-byte load to a word whose low byte has not been staged since the last program commit raises `err_order` in the next cycle, and that high byte is not stored.
- R4: A program commit changes only the low and high bytes that were staged. Every other byte of the page keeps its value.
- R5: A data load is indexed by `req_addr[1:0]`. A data commit writes staged byte b to data address `{req_addr[5:2], b}`, and unstaged bytes of that page keep their values.
- R6: A single data byte write (code 6) stores `req_data` at `req_addr[5:0]` whatever the old value was, and it leaves the staging buffer untouched.
- R7: An accepted commit or single write raises `busy` from the next cycle. `busy` stays high for exactly BUSY_CYCLES cycles (default 20).
- R8: Any request with code 1 to 6 made while `busy` is high is refused. `err_busy` rises in the next cycle, and neither the buffer nor the arrays change.
- R9: A commit empties its staging buffer, so a later commit with no new loads changes nothing.
- R10: `err_order` and `err_busy` are single-cycle pulses, only one of them is high at a time, and both are 0 in any cycle not caused by a faulty request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | 8 | Byte index for loads, page for commits, address for single writes |
| req_data | input | 8 | Byte to stage or write |
| rd_mem | input | 1 | Read select: 0 program, 1 data |
| rd_hi | input | 1 | Program read: 1 selects the high byte |
| rd_addr | input | 8 | Read address (word address for program, byte address for data) |
| rd_data | output | 8 | Combinational read data |
| busy | output | 1 | Self-timed write in progress |
| err_order | output | 1 | Pulse: high byte loaded before its low byte |
| err_busy | output | 1 | Pulse: request refused while busy |

## Verification
Corruption in a staging valid bit stays hidden until the next commit. At that point the read port shows an unloaded byte overwriting a neighbour, or a loaded byte that is missing. The bench therefore reads whole words and bytes back right after each commit interval. A wrong busy counter or a wrong rejection decision shows one cycle after the request, on `busy` or `err_busy`. A per-cycle comparison against a behavioural model catches it at that same clock.

// File: rtl/pgbuf_pkg.sv
// Shared definitions for the page buffer block: operation codes and the
// erased byte value. Assumes a 3-bit operation field on the request port.
package pgbuf_pkg;
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_LD_PLO = 3'd1,
        OP_LD_PHI = 3'd2,
        OP_CM_P   = 3'd3,
        OP_LD_D   = 3'd4,
        OP_CM_D   = 3'd5,
        OP_WR_D   = 3'd6
    } pg_op_e;

    localparam logic [7:0] ERASED = 8'hFF;
endpackage

// File: rtl/pgbuf_bytebuf.sv
// Staging byte buffer with one valid bit per entry. A load writes one entry
// and marks it valid. A clear (or reset) empties the buffer back to the
// erased value. Assumes load and clear are never requested together.
module pgbuf_bytebuf import pgbuf_pkg::*; #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld,
    input  logic [IDX_W-1:0]        idx,
    input  logic [7:0]              din,
    input  logic                    clr,
    output logic [ENTRIES-1:0][7:0] bytes,
    output logic [ENTRIES-1:0]      vld
);
    // Hold staged bytes and their valid flags
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int e = 0; e < ENTRIES; e++) begin
                bytes[e] <= ERASED;
            end
            vld <= '0;
        end else if (ld) begin
            bytes[idx] <= din;
            vld[idx]   <= 1'b1;
        end
    end
endmodule

// File: rtl/pgbuf_busy_timer.sv
// Self-timed write interval. A start pulse loads the counter, and busy stays
// high while the counter is non-zero. Assumes start only arrives while idle.
module pgbuf_busy_timer #(
    parameter int CYCLES = 20,
    parameter int CNT_W  = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CNT_W-1:0] cnt;

    // Count down the remaining write time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_W'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/pgbuf_commit.sv
// Top of the page buffer: decodes requests, stages program words (low and
// high byte buffers) and data bytes, and commits staged bytes into the
// register-file arrays. A commit or single write starts the busy timer, and
// requests made while busy are refused with a flag. Assumes one request per
// cycle, and that the arrays hold the erased value after reset.
module pgbuf_commit import pgbuf_pkg::*; #(
    parameter int PWORD_BITS  = 5,
    parameter int PPAGE_BITS  = 3,
    parameter int DIDX_BITS   = 2,
    parameter int DPAGE_BITS  = 4,
    parameter int BUSY_CYCLES = 20,
    localparam int PADDR_W    = PWORD_BITS + PPAGE_BITS,
    localparam int DADDR_W    = DIDX_BITS + DPAGE_BITS,
    localparam int ADDR_W     = (PADDR_W > DADDR_W) ? PADDR_W : DADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic              rd_mem,
    input  logic              rd_hi,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              err_order,
    output logic              err_busy
);
    localparam int PWORDS = 1 << PWORD_BITS;
    localparam int PDEPTH = 1 << PADDR_W;
    localparam int DBYTES = 1 << DIDX_BITS;
    localparam int DDEPTH = 1 << DADDR_W;

    logic [7:0] plo  [PDEPTH];
    logic [7:0] phi  [PDEPTH];
    logic [7:0] dmem [DDEPTH];

    logic [PWORDS-1:0][7:0] lo_bytes, hi_bytes;
    logic [PWORDS-1:0]      lo_vld, hi_vld;
    logic [DBYTES-1:0][7:0] d_bytes;
    logic [DBYTES-1:0]      dvld;

    logic [PWORD_BITS-1:0] widx;
    logic [PPAGE_BITS-1:0] ppage;
    logic [DIDX_BITS-1:0]  didx;
    logic [DPAGE_BITS-1:0] dpage;
    logic is_def, accept, ld_lo, ld_hi_req, ld_hi, order_bad;
    logic cm_p, ld_d, cm_d, wr_d, start;

    // Field extraction and request decode
    assign widx   = req_addr[PWORD_BITS-1:0];
    assign ppage  = req_addr[PADDR_W-1:PWORD_BITS];
    assign didx   = req_addr[DIDX_BITS-1:0];
    assign dpage  = req_addr[DADDR_W-1:DIDX_BITS];

    assign is_def    = req_valid && (req_op != OP_NONE) && (req_op != 3'd7);
    assign accept    = is_def && !busy;
    assign ld_lo     = accept && (req_op == OP_LD_PLO);
    assign ld_hi_req = accept && (req_op == OP_LD_PHI);
    assign ld_hi     = ld_hi_req && lo_vld[widx];
    assign order_bad = ld_hi_req && !lo_vld[widx];
    assign cm_p      = accept && (req_op == OP_CM_P);
    assign ld_d      = accept && (req_op == OP_LD_D);
    assign cm_d      = accept && (req_op == OP_CM_D);
    assign wr_d      = accept && (req_op == OP_WR_D);
    assign start     = cm_p || cm_d || wr_d;

    pgbuf_bytebuf #(.ENTRIES(PWORDS), .IDX_W(PWORD_BITS)) lo_buf_i (
        .clk(clk), .rst_n(rst_n), .ld(ld_lo), .idx(widx), .din(req_data),
        .clr(cm_p), .bytes(lo_bytes), .vld(lo_vld)
    );

    pgbuf_bytebuf #(.ENTRIES(PWORDS), .IDX_W(PWORD_BITS)) hi_buf_i (
        .clk(clk), .rst_n(rst_n), .ld(ld_hi), .idx(widx), .din(req_data),
        .clr(cm_p), .bytes(hi_bytes), .vld(hi_vld)
    );

    pgbuf_bytebuf #(.ENTRIES(DBYTES), .IDX_W(DIDX_BITS)) d_buf_i (
        .clk(clk), .rst_n(rst_n), .ld(ld_d), .idx(didx), .din(req_data),
        .clr(cm_d), .bytes(d_bytes), .vld(dvld)
    );

    pgbuf_busy_timer #(.CYCLES(BUSY_CYCLES)) timer_i (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy)
    );

    // Register one-cycle error pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_order <= 1'b0;
            err_busy  <= 1'b0;
        end else begin
            err_order <= order_bad;
            err_busy  <= is_def && busy;
        end
    end

    // Program array: erase on reset, masked page commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < PDEPTH; a++) begin
                plo[a] <= ERASED;
                phi[a] <= ERASED;
            end
        end else if (cm_p) begin
            for (int w = 0; w < PWORDS; w++) begin
                if (lo_vld[w]) plo[{ppage, w[PWORD_BITS-1:0]}] <= lo_bytes[w];
                if (hi_vld[w]) phi[{ppage, w[PWORD_BITS-1:0]}] <= hi_bytes[w];
            end
        end
    end

    // Data array: erase on reset, masked page commit or single byte write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DDEPTH; a++) begin
                dmem[a] <= ERASED;
            end
        end else if (cm_d) begin
            for (int b = 0; b < DBYTES; b++) begin
                if (dvld[b]) dmem[{dpage, b[DIDX_BITS-1:0]}] <= d_bytes[b];
            end
        end else if (wr_d) begin
            dmem[req_addr[DADDR_W-1:0]] <= req_data;
        end
    end

    // Combinational read port
    always_comb begin
        if (rd_mem)     rd_data = dmem[rd_addr[DADDR_W-1:0]];
        else if (rd_hi) rd_data = phi[rd_addr[PADDR_W-1:0]];
        else            rd_data = plo[rd_addr[PADDR_W-1:0]];
    end
endmodule

// File: rtl/pgbuf_commit_chk.sv
// Assertion checker for pgbuf_commit, attached through bind. It observes the
// request port, the flags and the staging valid masks.
module pgbuf_commit_chk #(
    parameter int PWORD_BITS = 5,
    parameter int PWORDS     = 32,
    parameter int DBYTES     = 4,
    parameter int ADDR_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              busy,
    input logic              err_order,
    input logic              err_busy,
    input logic [PWORDS-1:0] lo_vld,
    input logic [PWORDS-1:0] hi_vld,
    input logic [DBYTES-1:0] dvld
);
    // R7
    commit_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && (req_op == 3'd3 || req_op == 3'd5 || req_op == 3'd6)) |=> busy);

    // R8
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy && req_op != 3'd0 && req_op != 3'd7) |=> err_busy);

    // R8
    busy_no_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy) |=> ($stable(lo_vld) && $stable(hi_vld) && $stable(dvld)));

    // R3
    order_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op == 3'd2 && !lo_vld[req_addr[PWORD_BITS-1:0]])
        |=> (err_order && $stable(hi_vld)));

    // R9
    clear_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op == 3'd3) |=> (lo_vld == '0 && hi_vld == '0));

    // R10
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_order, err_busy}));
endmodule

bind pgbuf_commit pgbuf_commit_chk #(
    .PWORD_BITS(PWORD_BITS), .PWORDS(PWORDS), .DBYTES(DBYTES), .ADDR_W(ADDR_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .busy(busy), .err_order(err_order), .err_busy(err_busy),
    .lo_vld(lo_vld), .hi_vld(hi_vld), .dvld(dvld)
);

// File: tb/pgbuf_commit_tb_top.sv
// Bench for pgbuf_commit: a behavioural reference model, updated at each
// rising edge, is compared with the flags on every falling edge and with the
// read port after each commit interval.
module pgbuf_commit_tb_top;
    localparam int BUSY = 20;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = 3'd0;
    logic [7:0] req_addr = 8'd0, req_data = 8'd0;
    logic       rd_mem = 1'b0, rd_hi = 1'b0;
    logic [7:0] rd_addr = 8'd0;
    logic [7:0] rd_data;
    logic       busy, err_order, err_busy;

    pgbuf_commit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .rd_mem(rd_mem), .rd_hi(rd_hi),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .err_order(err_order), .err_busy(err_busy)
    );

    // Reference model state
    int m_plo[256], m_phi[256], m_dm[64];
    int b_lo[32], b_hi[32], b_d[4];
    bit v_lo[32], v_hi[32], v_d[4];
    int m_cnt;
    bit m_eo, m_eb;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model update at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin m_plo[i] = 255; m_phi[i] = 255; end
            for (int i = 0; i < 64; i++) m_dm[i] = 255;
            for (int i = 0; i < 32; i++) begin b_lo[i] = 255; b_hi[i] = 255; v_lo[i] = 0; v_hi[i] = 0; end
            for (int i = 0; i < 4; i++) begin b_d[i] = 255; v_d[i] = 0; end
            m_cnt = 0; m_eo = 0; m_eb = 0;
        end else begin
            bit def, acc;
            int w, pg;
            def  = req_valid && req_op != 0 && req_op != 7;
            acc  = def && m_cnt == 0;
            m_eb = def && m_cnt != 0;
            m_eo = 0;
            if (m_cnt > 0) m_cnt--;
            if (acc) begin
                case (req_op)
                    3'd1: begin w = req_addr % 32; b_lo[w] = req_data; v_lo[w] = 1; end
                    3'd2: begin
                        w = req_addr % 32;
                        if (v_lo[w]) begin b_hi[w] = req_data; v_hi[w] = 1; end
                        else m_eo = 1;
                    end
                    3'd3: begin
                        pg = req_addr / 32;
                        for (int i = 0; i < 32; i++) begin
                            if (v_lo[i]) m_plo[pg*32+i] = b_lo[i];
                            if (v_hi[i]) m_phi[pg*32+i] = b_hi[i];
                            b_lo[i] = 255; b_hi[i] = 255; v_lo[i] = 0; v_hi[i] = 0;
                        end
                        m_cnt = BUSY;
                    end
                    3'd4: begin w = req_addr % 4; b_d[w] = req_data; v_d[w] = 1; end
                    3'd5: begin
                        pg = (req_addr / 4) % 16;
                        for (int i = 0; i < 4; i++) begin
                            if (v_d[i]) m_dm[pg*4+i] = b_d[i];
                            b_d[i] = 255; v_d[i] = 0;
                        end
                        m_cnt = BUSY;
                    end
                    3'd6: begin m_dm[req_addr % 64] = req_data; m_cnt = BUSY; end
                    default: ;
                endcase
            end
        end
    end

    // Per-cycle comparison of the flag outputs
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 busy", busy, (m_cnt != 0));
            chk("R8 R10 err_busy", err_busy, m_eb);
            chk("R3 R10 err_order", err_order, m_eo);
        end
    end

    task automatic op(int o, int a, int d);
        @(negedge clk);
        req_valid = 1'b1; req_op = o[2:0]; req_addr = a[7:0]; req_data = d[7:0];
        @(posedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd0;
        while (m_cnt != 0) @(negedge clk);
    endtask

    task automatic rd(string tag, bit mem, bit hi, int a);
        int exp;
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd0;
        rd_mem = mem; rd_hi = hi; rd_addr = a[7:0];
        #1;
        exp = mem ? m_dm[a % 64] : (hi ? m_phi[a % 256] : m_plo[a % 256]);
        chk(tag, rd_data, exp);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 busy", busy, 0);
        rd("R1", 0, 0, 0);
        rd("R1", 0, 1, 255);
        rd("R1", 1, 0, 63);

        // R2 staging and program page commit; load page bits ignored
        op(1, 8'h00, 8'h11); op(2, 8'h00, 8'h12);
        op(1, 8'hE1, 8'h21); op(2, 8'h01, 8'h22);
        op(1, 8'h1F, 8'h31); op(2, 8'h3F, 8'h32);
        op(3, 2 << 5, 0);
        @(negedge clk); req_valid = 1'b0; req_op = 3'd0;
        n = 0;
        while (busy === 1'b1) begin n++; @(negedge clk); end
        chk("R7 busy length", n, BUSY);
        rd("R2", 0, 0, 64); rd("R2", 0, 1, 64);
        rd("R2", 0, 0, 65); rd("R2", 0, 1, 65);
        rd("R2", 0, 0, 95); rd("R2", 0, 1, 95);
        rd("R2", 0, 0, 1);

        // R3 order error and R4 masked commit
        op(1, 3, 8'h33); op(2, 4, 8'h44);
        op(3, 2 << 5, 0); wait_idle();
        rd("R4", 0, 0, 67); rd("R4", 0, 1, 67);
        rd("R3", 0, 1, 68); rd("R4", 0, 0, 68);
        rd("R4", 0, 0, 64); rd("R4", 0, 1, 65);

        // R8 rejection while busy, R9 buffer empty after commit
        op(1, 5, 8'h55); op(3, 3 << 5, 0);
        op(1, 6, 8'h66); op(3, 3 << 5, 0); op(6, 9, 8'h99);
        wait_idle();
        op(3, 5 << 5, 0); wait_idle();
        rd("R8", 0, 0, 101); rd("R8", 0, 0, 102);
        rd("R9", 0, 0, 165); rd("R9", 0, 0, 166);
        rd("R8", 1, 0, 9);

        // R5 data page commit
        op(4, 0, 8'hD0); op(4, 2, 8'hD2); op(5, 5 << 2, 0); wait_idle();
        rd("R5", 1, 0, 20); rd("R5", 1, 0, 21); rd("R5", 1, 0, 22); rd("R5", 1, 0, 23);
        op(4, 1, 8'hE1); op(5, 5 << 2, 0); wait_idle();
        rd("R5", 1, 0, 21); rd("R5", 1, 0, 20);

        // R6 single byte write, buffer untouched
        op(4, 3, 8'h77); op(6, 22, 8'h3C); wait_idle();
        rd("R6", 1, 0, 22);
        op(6, 22, 8'hA5); wait_idle();
        rd("R6", 1, 0, 22);
        op(5, 1 << 2, 0); wait_idle();
        rd("R6", 1, 0, 7); rd("R6", 1, 0, 4);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule